// File: doc/BRIEF.md
# Offload Threshold Sampling Controller

This block picks, at run time, the run-length threshold above which an operating-system invocation is moved to a dedicated core. It counts retired instructions and uses them to mark out epochs. After reset it runs one profiling epoch. In that epoch it measures how many of the retired instructions were privileged, and from that share it picks a starting threshold. It then enters a sampling phase: it tries the current threshold and its neighbours on a fixed ladder, one epoch each. At the end of each sampling epoch it waits for an averaged cache hit rate, which logic outside the block measures and returns.

When the sampling phase ends, the controller either keeps the current threshold or moves to a neighbour whose hit rate is clearly better. It then runs with that choice for a long run interval before it samples again. When a resample confirms the choice, the next run interval is twice as long, up to a ceiling. When the choice changes, the interval drops back to its base length. The threshold goes straight to the run-length predictor. Epoch and interval lengths are parameters, so a short test configuration needs only a few hundred instructions per round.

Top module: `tsc_threshold_ctrl`

## Requirements
- R1: While reset is active and right after it, `threshold_o` is 10000 and `metric_req_o` is low. The controller is then in its profiling epoch.
- R2: The profiling epoch lasts SAMPLE_LEN retired instructions. When it ends, the starting rung is 2 (threshold 1000) if privileged instructions times ten exceed SAMPLE_LEN, and rung 4 (threshold 10000) otherwise. A share of exactly 10 % therefore gives 10000.
- R3: A sampling phase tries candidates in this fixed order: the current rung, then the rung below it, then the rung above it. A neighbour that would fall off either end of the ladder is skipped. Each candidate epoch lasts SAMPLE_LEN retired instructions and shows the candidate on `threshold_o`. After each candidate epoch, `metric_req_o` stays high with `threshold_o` held until `metric_valid_i` is seen.
- R4: A neighbour replaces the current rung only if its hit rate is at least the current hit rate plus MARGIN. Hit rates are in units of 0.01 %, so the default margin of 100 is one percentage point.
- R5: If both neighbours qualify, the one with the higher hit rate wins. On equal hit rates the lower rung wins.
- R6: The run interval that follows the first sampling phase is RUN_LEN instructions. After a later sampling phase that keeps the rung, the interval is twice the previous one, up to RUN_LEN*MAX_MULT. After any change of rung it is RUN_LEN again. The next sampling phase starts when the interval ends.
- R7: `metric_valid_i` has no effect unless `metric_req_o` is high. Retired instructions are not counted while `metric_req_o` is high, nor in the one decision cycle that follows the last metric of a sampling phase.
- R8: `threshold_o` always holds a ladder value. The ladder, by rung index 0 to 4, is 0, 100, 1000, 5000, 10000. During a run interval `threshold_o` shows the chosen rung, starting two cycles after the last metric is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | One instruction retired this cycle |
| priv_i | input | 1 | The retired instruction ran in privileged mode |
| metric_valid_i | input | 1 | `metric_i` carries the hit rate for the epoch that just ended |
| metric_i | input | METRIC_W | Averaged hit rate in units of 0.01 % |
| metric_req_o | output | 1 | A sampling epoch has ended and its hit rate is awaited |
| threshold_o | output | 16 | Offload threshold for the predictor |

## Verification
The bench aims at four corner cases. The first is a privileged share of exactly 10 %: a design that compares with greater-or-equal would start at 1000 instead of 10000. The second is a neighbour that beats the current hit rate by one unit less than the margin and then by exactly the margin: an off-by-one in that compare would move the threshold one round too early or too late. The third is the two ends of the ladder. A design that does not skip the clamped duplicate asks for one metric too many, and the bench's instruction counts and expected candidates then go out of step. The fourth is a run of stable resamples long enough to reach the interval ceiling, followed by a change: a design that lets the interval grow past the ceiling, or does not reset it on a change, shows wrong instruction counts before the next request. Stray metric strobes and retire pulses during the wait also check that nothing outside the request window is taken in.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  localparam int NUM_RUNGS = 5;
  localparam int RUNG_W    = 3;
  localparam int THR_W     = 16;

  localparam logic [RUNG_W-1:0] TOP_RUNG     = RUNG_W'(NUM_RUNGS - 1);
  localparam logic [RUNG_W-1:0] HI_PRIV_RUNG = RUNG_W'(2);

  typedef enum logic [2:0] {
    ST_PROFILE = 3'd0,
    ST_SAMPLE  = 3'd1,
    ST_WAIT    = 3'd2,
    ST_DECIDE  = 3'd3,
    ST_RUN     = 3'd4
  } state_e;

  typedef enum logic [1:0] {
    SL_CUR = 2'd0,
    SL_LO  = 2'd1,
    SL_HI  = 2'd2
  } slot_e;

  function automatic logic [THR_W-1:0] rung_thr(input logic [RUNG_W-1:0] r);
    case (r)
      3'd0:    return 16'd0;
      3'd1:    return 16'd100;
      3'd2:    return 16'd1000;
      3'd3:    return 16'd5000;
      default: return 16'd10000;
    endcase
  endfunction

endpackage

// File: rtl/tsc_epoch_counter.sv
module tsc_epoch_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = en_i && step_i && (cnt_q == len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (done_o) begin
      cnt_q <= '0;
    end else if (en_i && step_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/tsc_priv_profiler.sv
module tsc_priv_profiler #(
  parameter int CNT_W      = 8,
  parameter int SAMPLE_LEN = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic step_i,
  input  logic priv_i,
  input  logic done_i,
  output logic high_priv_o
);

  localparam int WW = CNT_W + 4;
  localparam logic [WW-1:0] TEN = WW'(10);
  localparam logic [WW-1:0] LIM = WW'(SAMPLE_LEN);

  logic [CNT_W-1:0] priv_q;
  logic [WW-1:0]    total;

  // include the instruction retiring in the closing cycle
  assign total       = WW'(priv_q) + WW'(step_i && priv_i);
  assign high_priv_o = (total * TEN) > LIM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q <= '0;
    end else if (done_i) begin
      priv_q <= '0;
    end else if (en_i && step_i && priv_i) begin
      priv_q <= priv_q + 1'b1;
    end
  end

endmodule

// File: rtl/tsc_pick.sv
module tsc_pick #(
  parameter int                METRIC_W = 14,
  parameter logic [METRIC_W-1:0] MARGIN = METRIC_W'(100)
) (
  input  logic [tsc_pkg::RUNG_W-1:0] cur_rung_i,
  input  logic                       has_lo_i,
  input  logic                       has_hi_i,
  input  logic [METRIC_W-1:0]        hit_cur_i,
  input  logic [METRIC_W-1:0]        hit_lo_i,
  input  logic [METRIC_W-1:0]        hit_hi_i,
  output logic [tsc_pkg::RUNG_W-1:0] next_rung_o
);

  logic [METRIC_W:0] bar;
  logic              lo_ok, hi_ok;

  assign bar   = {1'b0, hit_cur_i} + {1'b0, MARGIN};
  assign lo_ok = has_lo_i && ({1'b0, hit_lo_i} >= bar);
  assign hi_ok = has_hi_i && ({1'b0, hit_hi_i} >= bar);

  always_comb begin
    next_rung_o = cur_rung_i;
    if (lo_ok && hi_ok) begin
      next_rung_o = (hit_hi_i > hit_lo_i) ? cur_rung_i + 1'b1 : cur_rung_i - 1'b1;
    end else if (lo_ok) begin
      next_rung_o = cur_rung_i - 1'b1;
    end else if (hi_ok) begin
      next_rung_o = cur_rung_i + 1'b1;
    end
  end

endmodule

// File: rtl/tsc_run_scaler.sv
module tsc_run_scaler #(
  parameter int CNT_W   = 8,
  parameter int RUN_LEN = 40,
  parameter int MAX_SH  = 2,
  parameter int SH_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             update_i,
  input  logic             restart_i,
  output logic [SH_W-1:0]  sh_o,
  output logic [CNT_W-1:0] run_len_o
);

  localparam logic [SH_W-1:0] SH_MAX = SH_W'(MAX_SH);

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (update_i) begin
      if (restart_i)             sh_q <= '0;
      else if (sh_q != SH_MAX)   sh_q <= sh_q + 1'b1;
    end
  end

  assign sh_o      = sh_q;
  assign run_len_o = CNT_W'(RUN_LEN) << sh_q;

endmodule

// File: rtl/tsc_threshold_ctrl.sv
module tsc_threshold_ctrl #(
  parameter int                  SAMPLE_LEN = 25_000_000,
  parameter int                  RUN_LEN    = 100_000_000,
  parameter int                  MAX_MULT   = 8,
  parameter int                  METRIC_W   = 14,
  parameter logic [METRIC_W-1:0] MARGIN     = METRIC_W'(100)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       retire_i,
  input  logic                       priv_i,
  input  logic                       metric_valid_i,
  input  logic [METRIC_W-1:0]        metric_i,
  output logic                       metric_req_o,
  output logic [tsc_pkg::THR_W-1:0]  threshold_o
);

  import tsc_pkg::*;

  localparam int MAX_SH = $clog2(MAX_MULT);
  localparam int SH_W   = (MAX_SH < 1) ? 1 : $clog2(MAX_SH + 1);
  localparam int CNT_W  = $clog2(RUN_LEN * MAX_MULT + 1);

  state_e                state_q;
  slot_e                 slot_q;
  logic [RUNG_W-1:0]     cur_rung_q, try_rung, next_rung;
  logic                  first_q;
  logic [METRIC_W-1:0]   hit_q [3];
  logic                  has_lo, has_hi;
  logic                  cnt_en, ep_done, high_priv;
  logic [CNT_W-1:0]      ep_len, run_len;
  logic [SH_W-1:0]       run_sh;
  logic                  accept;

  assign has_lo = (cur_rung_q != '0);
  assign has_hi = (cur_rung_q != TOP_RUNG);
  assign accept = (state_q == ST_WAIT) && metric_valid_i;
  assign cnt_en = (state_q == ST_PROFILE) || (state_q == ST_SAMPLE) || (state_q == ST_RUN);
  assign ep_len = (state_q == ST_RUN) ? run_len : CNT_W'(SAMPLE_LEN);

  always_comb begin
    case (slot_q)
      SL_LO:   try_rung = cur_rung_q - 1'b1;
      SL_HI:   try_rung = cur_rung_q + 1'b1;
      default: try_rung = cur_rung_q;
    endcase
  end

  tsc_epoch_counter #(.CNT_W(CNT_W)) i_epoch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cnt_en),
    .step_i (retire_i),
    .len_i  (ep_len),
    .done_o (ep_done)
  );

  tsc_priv_profiler #(.CNT_W(CNT_W), .SAMPLE_LEN(SAMPLE_LEN)) i_prof (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (state_q == ST_PROFILE),
    .step_i      (retire_i),
    .priv_i      (priv_i),
    .done_i      (ep_done && (state_q == ST_PROFILE)),
    .high_priv_o (high_priv)
  );

  tsc_pick #(.METRIC_W(METRIC_W), .MARGIN(MARGIN)) i_pick (
    .cur_rung_i  (cur_rung_q),
    .has_lo_i    (has_lo),
    .has_hi_i    (has_hi),
    .hit_cur_i   (hit_q[0]),
    .hit_lo_i    (hit_q[1]),
    .hit_hi_i    (hit_q[2]),
    .next_rung_o (next_rung)
  );

  tsc_run_scaler #(.CNT_W(CNT_W), .RUN_LEN(RUN_LEN), .MAX_SH(MAX_SH), .SH_W(SH_W)) i_scale (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .update_i  (state_q == ST_DECIDE),
    .restart_i (first_q || (next_rung != cur_rung_q)),
    .sh_o      (run_sh),
    .run_len_o (run_len)
  );

  for (genvar g = 0; g < 3; g++) begin : g_hit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          hit_q[g] <= '0;
      else if (accept && slot_q == slot_e'(g)) hit_q[g] <= metric_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_PROFILE;
      slot_q     <= SL_CUR;
      cur_rung_q <= TOP_RUNG;
      first_q    <= 1'b1;
    end else begin
      case (state_q)
        ST_PROFILE: if (ep_done) begin
          cur_rung_q <= high_priv ? HI_PRIV_RUNG : TOP_RUNG;
          slot_q     <= SL_CUR;
          state_q    <= ST_SAMPLE;
        end
        ST_SAMPLE: if (ep_done) state_q <= ST_WAIT;
        ST_WAIT: if (metric_valid_i) begin
          // order: current, below, above; clamped neighbours skipped
          if (slot_q == SL_CUR && has_lo) begin
            slot_q  <= SL_LO;
            state_q <= ST_SAMPLE;
          end else if (slot_q != SL_HI && has_hi) begin
            slot_q  <= SL_HI;
            state_q <= ST_SAMPLE;
          end else begin
            state_q <= ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          cur_rung_q <= next_rung;
          first_q    <= 1'b0;
          slot_q     <= SL_CUR;
          state_q    <= ST_RUN;
        end
        ST_RUN: if (ep_done) state_q <= ST_SAMPLE;
        default: state_q <= ST_PROFILE;
      endcase
    end
  end

  assign metric_req_o = (state_q == ST_WAIT);

  always_comb begin
    case (state_q)
      ST_PROFILE:          threshold_o = rung_thr(TOP_RUNG);
      ST_SAMPLE, ST_WAIT:  threshold_o = rung_thr(try_rung);
      default:             threshold_o = rung_thr(cur_rung_q);
    endcase
  end

endmodule

// File: rtl/tsc_threshold_ctrl_chk.sv
module tsc_threshold_ctrl_chk #(
  parameter int MAX_SH = 3,
  parameter int SH_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              retire_i,
  input logic              metric_valid_i,
  input logic              metric_req_o,
  input logic [15:0]       threshold_o,
  input tsc_pkg::state_e   state_q,
  input logic [SH_W-1:0]   run_sh
);

  a_r3_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    metric_req_o && !metric_valid_i |=> metric_req_o);

  a_r3_thr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    metric_req_o && !metric_valid_i |=> $stable(threshold_o));

  a_r3_req_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    metric_req_o && metric_valid_i |=> !metric_req_o);

  a_r7_req_needs_retire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !metric_req_o && !retire_i |=> !metric_req_o);

  a_r8_on_ladder: assert property (@(posedge clk_i) disable iff (!rst_ni)
    threshold_o == 16'd0 || threshold_o == 16'd100 || threshold_o == 16'd1000 ||
    threshold_o == 16'd5000 || threshold_o == 16'd10000);

  a_r2_profile_thr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == tsc_pkg::ST_PROFILE |-> threshold_o == 16'd10000 && !metric_req_o);

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_sh <= SH_W'(MAX_SH));

endmodule

bind tsc_threshold_ctrl tsc_threshold_ctrl_chk #(.MAX_SH(MAX_SH), .SH_W(SH_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .retire_i       (retire_i),
  .metric_valid_i (metric_valid_i),
  .metric_req_o   (metric_req_o),
  .threshold_o    (threshold_o),
  .state_q        (state_q),
  .run_sh         (run_sh)
);

// File: tb/test_tsc_threshold_ctrl.sv
module test_tsc_threshold_ctrl;

  localparam int SAMPLE_LEN = 20;
  localparam int RUN_LEN    = 40;
  localparam int MAX_MULT   = 4;
  localparam int MAX_SH     = 2;
  localparam int METRIC_W   = 14;
  localparam int MARGIN     = 100;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                retire_i = 1'b0;
  logic                priv_i = 1'b0;
  logic                metric_valid_i = 1'b0;
  logic [METRIC_W-1:0] metric_i = '0;
  logic                metric_req_o;
  logic [15:0]         threshold_o;

  int checks = 0;
  int errors = 0;

  int exp_cur, exp_sh, pre_len;
  bit exp_first;
  int tab [5];

  always #10 clk_i = ~clk_i;

  tsc_threshold_ctrl #(
    .SAMPLE_LEN (SAMPLE_LEN),
    .RUN_LEN    (RUN_LEN),
    .MAX_MULT   (MAX_MULT),
    .METRIC_W   (METRIC_W),
    .MARGIN     (METRIC_W'(MARGIN))
  ) i_tsc_threshold_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .retire_i       (retire_i),
    .priv_i         (priv_i),
    .metric_valid_i (metric_valid_i),
    .metric_i       (metric_i),
    .metric_req_o   (metric_req_o),
    .threshold_o    (threshold_o)
  );

  function automatic int lad(int r);
    case (r)
      0: return 0;
      1: return 100;
      2: return 1000;
      3: return 5000;
      default: return 10000;
    endcase
  endfunction

  function automatic int pick(int cur);
    bit lo_ok, hi_ok;
    lo_ok = (cur > 0) && (tab[(cur > 0) ? cur - 1 : 0] >= tab[cur] + MARGIN);
    hi_ok = (cur < 4) && (tab[(cur < 4) ? cur + 1 : 4] >= tab[cur] + MARGIN);
    if (lo_ok && hi_ok) return (tab[cur + 1] > tab[cur - 1]) ? cur + 1 : cur - 1;
    if (lo_ok) return cur - 1;
    if (hi_ok) return cur + 1;
    return cur;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_tab(input int a, input int b, input int c, input int d, input int e);
    tab[0] = a; tab[1] = b; tab[2] = c; tab[3] = d; tab[4] = e;
  endtask

  task automatic do_reset(input int quota);
    rst_ni = 1'b0; retire_i = 1'b0; priv_i = 1'b0; metric_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(threshold_o == 16'd10000, "R1 reset threshold", threshold_o, 10000);
    chk(!metric_req_o, "R1 reset req", metric_req_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(threshold_o == 16'd10000, "R1 after reset threshold", threshold_o, 10000);
    exp_cur   = (quota * 10 > SAMPLE_LEN) ? 2 : 4;
    exp_first = 1'b1;
    exp_sh    = 0;
    pre_len   = SAMPLE_LEN;
  endtask

  // retire one instruction per cycle until a metric is requested
  task automatic wait_req(input int quota, output int n, output int thr);
    n = 0;
    while (!metric_req_o) begin
      retire_i       = 1'b1;
      priv_i         = (n < quota);
      metric_valid_i = ($urandom % 6 == 0);
      metric_i       = METRIC_W'(9999);
      n++;
      @(negedge clk_i);
    end
    retire_i = 1'b0; priv_i = 1'b0; metric_valid_i = 1'b0;
    thr = threshold_o;
  endtask

  task automatic deliver(input int hit, input bit stray);
    if (stray) begin
      retire_i = 1'b1;
      repeat (3) @(negedge clk_i);
      retire_i = 1'b0;
      chk(metric_req_o, "R7 req held under retire", metric_req_o, 1);
    end
    metric_valid_i = 1'b1;
    metric_i       = METRIC_W'(hit);
    @(negedge clk_i);
    metric_valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic round(input int quota);
    int cands [3];
    int nc, n, thr, nxt, expn;
    nc = 0;
    cands[nc++] = exp_cur;
    if (exp_cur > 0) cands[nc++] = exp_cur - 1;
    if (exp_cur < 4) cands[nc++] = exp_cur + 1;
    for (int k = 0; k < nc; k++) begin
      wait_req(quota, n, thr);
      expn = SAMPLE_LEN + ((k == 0) ? pre_len : 0);
      if (k == 0 && exp_first) chk(n == expn, "R2 profile plus first epoch length", n, expn);
      else if (k == 0)         chk(n == expn, "R6 run interval plus epoch length", n, expn);
      else                     chk(n == expn, "R3 candidate epoch length", n, expn);
      chk(thr == lad(cands[k]), "R3 candidate order and value", thr, lad(cands[k]));
      deliver(tab[cands[k]], k == 1);
    end
    nxt = pick(exp_cur);
    chk(threshold_o == 16'(lad(nxt)), "R4 R5 R8 chosen threshold", threshold_o, lad(nxt));
    if (exp_first || nxt != exp_cur) exp_sh = 0;
    else if (exp_sh < MAX_SH)        exp_sh++;
    exp_first = 1'b0;
    exp_cur   = nxt;
    pre_len   = RUN_LEN << exp_sh;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));

    // exactly 10 % privileged -> 10000; stable rounds reach the interval ceiling
    do_reset(2);
    set_tab(5000, 5000, 5000, 5000, 5000);
    for (int i = 0; i < 4; i++) round(2);
    set_tab(5000, 5000, 5000, 5099, 5000);   // R4: one short of margin
    round(2);
    set_tab(5000, 5000, 5000, 5100, 5000);   // R4: exactly margin, R6 resets
    round(2);
    set_tab(5000, 5000, 5000, 5000, 5000);
    round(2);

    // above 10 % -> 1000; ties and preference between both neighbours
    do_reset(3);
    set_tab(5000, 5200, 5000, 5200, 5000);   // R5 tie -> lower
    round(3);
    set_tab(5000, 5000, 5300, 4800, 5000);   // at rung 1: above beats below
    tab[0] = 5150;
    round(3);
    set_tab(5000, 5300, 5000, 5150, 5000);   // at rung 2: below wins
    round(3);
    set_tab(5500, 5000, 5000, 5000, 5000);   // to rung 0
    round(3);
    set_tab(5000, 5000, 5000, 5000, 5000);   // bottom clamp
    round(3);
    round(3);

    // random profiles and hit tables
    for (int s = 0; s < 3; s++) begin
      int q;
      q = $urandom % (SAMPLE_LEN + 1);
      do_reset(q);
      for (int r = 0; r < 8; r++) begin
        for (int j = 0; j < 5; j++) tab[j] = 5000 + ($urandom % 250);
        round(q);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule